// File: doc/BRIEF.md
# Two-Wire Configuration Register Sink

This block is a write-only slave on a two-wire serial bus. Its only job is to load a bank of configuration registers from a host. It oversamples the bus clock and data lines with a faster system clock. It finds start and stop conditions and assembles bytes, most significant bit first. Each byte of a frame addressed to it is acknowledged by pulling the data line low. It never returns data to the master.

A frame has a fixed length of eleven bytes:

- one address byte, which includes the write bit;
- two header bytes, whose values do not matter but which must be present;
- eight data bytes, one for each register.

Data bytes are staged in a shadow bank. The live registers take the new values only when a stop condition ends a complete, correctly addressed frame. A frame that is truncated, too long, wrongly addressed or broken by a repeated start leaves the live registers as they were.

The live registers come out on two ports. The first is the raw register values. The second is an output-enable vector in which reserved bit positions always read zero. A zero in this vector means the matching clock output is held low.

Top module: `cfg_smb_sink`

## Requirements
- R1: After reset, `cfg_o` equals the parameter `RST_VAL`, `oe_o` equals `RST_VAL & ~RSVD_MASK`, and `sda_pull_o` is 0.
- R2: A frame has eleven bytes. The first is address 8'hD2, then two header bytes, then data bytes 0 to 7. When a stop follows it, register i (bits 8*i+7 down to 8*i of `cfg_o`) takes data byte i.
- R3: If the first byte is not 8'hD2, that byte and every later byte of the frame are not acknowledged, and no register changes.
- R4: The values of the second and third bytes have no effect on the result, but both bytes count toward the eleven-byte length.
- R5: `sda_pull_o` goes high only during the ninth clock of a byte belonging to a correctly addressed frame. It is 0 whenever the bus is idle.
- R6: A frame that ends with a stop after fewer than eleven bytes leaves every register unchanged.
- R7: A repeated start in the middle of a frame discards the partial frame. It restarts byte counting at the address byte, and only a complete frame after it is loaded.
- R8: `oe_o` equals `cfg_o` with every bit set in `RSVD_MASK` forced to 0, even when those bits were written as 1.
- R9: A twelfth byte in a frame is not acknowledged, and that frame is not loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | High to pull the data line low (acknowledge) |
| cfg_o | output | NREG*8 | Live register bank, register i in byte lane i |
| oe_o | output | NREG*8 | Output-enable vector, reserved positions zero |

## Verification
The assertions assume that the bus clock stays in each phase for many system clocks. They also assume that the data line changes only while the clock is low, except for start and stop conditions. Under these assumptions, the acknowledge drive always begins while the synchronized clock is low, and a start is never mistaken for a data bit. The bench holds every bus phase for eight system clocks. It models the data line as open drain, combining the master's drive and the block's pull. It changes data only in the low phase, so every transfer stays within these assumptions.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  // Bytes preceding the register payload: address, command, count.
  localparam int HDR_BYTES = 3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_BITS,
    RX_ACK_SETUP,
    RX_ACK_LOW,
    RX_ACK_HIGH
  } rx_state_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_bit,
  output logic rise_p,
  output logic fall_p,
  output logic start_p,
  output logic stop_p
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;
  logic              scl_s;
  logic              sda_s;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      scl_lvl <= 1'b1;
      sda_bit <= 1'b1;
      rise_p  <= 1'b0;
      fall_p  <= 1'b0;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
    end else begin
      scl_d   <= scl_s;
      sda_d   <= sda_s;
      scl_lvl <= scl_s;
      sda_bit <= sda_s;
      rise_p  <= scl_s & ~scl_d;
      fall_p  <= ~scl_s & scl_d;
      start_p <= scl_s & scl_d & sda_d & ~sda_s;
      stop_p  <= scl_s & scl_d & ~sda_d & sda_s;
    end
  end

endmodule

// File: rtl/smb_byte_rx.sv
module smb_byte_rx
  import smb_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise_p,
  input  logic       fall_p,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic       sda_bit,
  input  logic       ack_ok,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       sda_low
);

  rx_state_t  state;
  logic [2:0] bit_cnt;
  logic [7:0] shreg;

  assign rx_byte = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      sda_low   <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start_p) begin
        state   <= RX_BITS;
        bit_cnt <= '0;
        sda_low <= 1'b0;
      end else if (stop_p) begin
        state   <= RX_IDLE;
        sda_low <= 1'b0;
      end else begin
        case (state)
          RX_BITS: begin
            if (rise_p) begin
              shreg <= {shreg[6:0], sda_bit};
              if (bit_cnt == 3'd7) begin
                byte_done <= 1'b1;
                state     <= RX_ACK_SETUP;
              end else begin
                bit_cnt <= bit_cnt + 3'd1;
              end
            end
          end
          RX_ACK_SETUP: begin
            if (fall_p) begin
              if (ack_ok) begin
                sda_low <= 1'b1;
                state   <= RX_ACK_LOW;
              end else begin
                state <= RX_IDLE;
              end
            end
          end
          RX_ACK_LOW: begin
            if (rise_p) state <= RX_ACK_HIGH;
          end
          RX_ACK_HIGH: begin
            if (fall_p) begin
              sda_low <= 1'b0;
              bit_cnt <= '0;
              state   <= RX_BITS;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_frame_ctl.sv
module smb_frame_ctl
  import smb_cfg_pkg::*;
#(
  parameter int          NREG     = 8,
  parameter logic [7:0]  DEV_ADDR = 8'hD2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  output logic              ack_ok,
  output logic              addr_hit,
  output logic [$clog2(HDR_BYTES+NREG+2)-1:0] byte_cnt,
  output logic              commit_p,
  output logic [NREG*8-1:0] shadow
);

  localparam int FRAME_LEN = HDR_BYTES + NREG;
  localparam int CW        = $clog2(FRAME_LEN + 2);
  localparam logic [CW-1:0] CNT_MAX  = CW'(FRAME_LEN + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_ok   <= 1'b0;
      addr_hit <= 1'b0;
      byte_cnt <= '0;
      commit_p <= 1'b0;
    end else begin
      commit_p <= stop_p & addr_hit & (byte_cnt == CNT_FULL);
      if (start_p) begin
        ack_ok   <= 1'b0;
        addr_hit <= 1'b0;
        byte_cnt <= '0;
      end else if (byte_done) begin
        if (byte_cnt == '0) begin
          addr_hit <= (rx_byte == DEV_ADDR);
          ack_ok   <= (rx_byte == DEV_ADDR);
        end else begin
          ack_ok <= addr_hit & (byte_cnt < CNT_FULL);
        end
        if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
      end
    end
  end

  // Shadow lanes, one per register; written only for payload positions.
  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          shadow[gi*8 +: 8] <= '0;
        end else if (byte_done && addr_hit && byte_cnt == CW'(HDR_BYTES + gi)) begin
          shadow[gi*8 +: 8] <= rx_byte;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank #(
  parameter int                NREG      = 8,
  parameter logic [NREG*8-1:0] RST_VAL   = '0,
  parameter logic [NREG*8-1:0] RSVD_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_p,
  input  logic [NREG*8-1:0] shadow,
  output logic [NREG*8-1:0] cfg_o,
  output logic [NREG*8-1:0] oe_o
);

  logic [NREG*8-1:0] live;

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          live[gi*8 +: 8]  <= RST_VAL[gi*8 +: 8];
          cfg_o[gi*8 +: 8] <= RST_VAL[gi*8 +: 8];
          oe_o[gi*8 +: 8]  <= RST_VAL[gi*8 +: 8] & ~RSVD_MASK[gi*8 +: 8];
        end else begin
          if (commit_p) live[gi*8 +: 8] <= shadow[gi*8 +: 8];
          cfg_o[gi*8 +: 8] <= live[gi*8 +: 8];
          oe_o[gi*8 +: 8]  <= live[gi*8 +: 8] & ~RSVD_MASK[gi*8 +: 8];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cfg_smb_sink.sv
module cfg_smb_sink
  import smb_cfg_pkg::*;
#(
  parameter int                NREG        = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [7:0]        DEV_ADDR    = 8'hD2,
  parameter logic [NREG*8-1:0] RST_VAL     = 64'h00_3F_7F_FF_FF_C3_FF_0A,
  parameter logic [NREG*8-1:0] RSVD_MASK   = 64'hFF_00_00_00_00_00_00_F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [NREG*8-1:0] cfg_o,
  output logic [NREG*8-1:0] oe_o
);

  localparam int CW = $clog2(HDR_BYTES + NREG + 2);

  logic              scl_lvl, sda_bit, rise_p, fall_p, start_p, stop_p;
  logic              byte_done, ack_ok, addr_hit, commit_p;
  logic [7:0]        rx_byte;
  logic [CW-1:0]     byte_cnt;
  logic [NREG*8-1:0] shadow;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_bit(sda_bit), .rise_p(rise_p), .fall_p(fall_p),
    .start_p(start_p), .stop_p(stop_p)
  );

  smb_byte_rx u_rx (
    .clk(clk), .rst(rst), .rise_p(rise_p), .fall_p(fall_p),
    .start_p(start_p), .stop_p(stop_p), .sda_bit(sda_bit), .ack_ok(ack_ok),
    .byte_done(byte_done), .rx_byte(rx_byte), .sda_low(sda_pull_o)
  );

  smb_frame_ctl #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_frame (
    .clk(clk), .rst(rst), .start_p(start_p), .stop_p(stop_p),
    .byte_done(byte_done), .rx_byte(rx_byte), .ack_ok(ack_ok),
    .addr_hit(addr_hit), .byte_cnt(byte_cnt), .commit_p(commit_p),
    .shadow(shadow)
  );

  smb_cfg_bank #(.NREG(NREG), .RST_VAL(RST_VAL), .RSVD_MASK(RSVD_MASK)) u_bank (
    .clk(clk), .rst(rst), .commit_p(commit_p), .shadow(shadow),
    .cfg_o(cfg_o), .oe_o(oe_o)
  );

endmodule

// File: rtl/cfg_smb_sink_chk.sv
module cfg_smb_sink_chk #(
  parameter int                NREG      = 8,
  parameter int                CW        = 4,
  parameter logic [NREG*8-1:0] RSVD_MASK = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_lvl,
  input logic              start_p,
  input logic              sda_pull_o,
  input logic              addr_hit,
  input logic              commit_p,
  input logic [CW-1:0]     byte_cnt,
  input logic [NREG*8-1:0] cfg_o,
  input logic [NREG*8-1:0] oe_o
);

  localparam int FRAME_LEN = 3 + NREG;

  assert_pull_starts_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_lvl);

  assert_no_pull_unmatched_R3: assert property (@(posedge clk) disable iff (rst)
    sda_pull_o |-> addr_hit);

  assert_commit_full_frame_R2: assert property (@(posedge clk) disable iff (rst)
    commit_p |-> ($past(byte_cnt) == CW'(FRAME_LEN)) && $past(addr_hit));

  assert_cfg_change_needs_commit_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> $past(commit_p, 2));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= CW'(FRAME_LEN + 1));

  assert_oe_masked_R8: assert property (@(posedge clk) disable iff (rst)
    oe_o == (cfg_o & ~RSVD_MASK));

  assert_start_releases_R7: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !sda_pull_o);

endmodule

bind cfg_smb_sink cfg_smb_sink_chk #(
  .NREG(NREG), .CW(CW), .RSVD_MASK(RSVD_MASK)
) u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .start_p(start_p),
  .sda_pull_o(sda_pull_o), .addr_hit(addr_hit), .commit_p(commit_p),
  .byte_cnt(byte_cnt), .cfg_o(cfg_o), .oe_o(oe_o)
);

// File: tb/tb_cfg_smb_sink.sv
module tb_cfg_smb_sink;

  localparam int          Q     = 8;
  localparam logic [63:0] DEFV  = 64'h00_3F_7F_FF_FF_C3_FF_0A;
  localparam logic [63:0] MASK  = 64'hFF_00_00_00_00_00_00_F0;
  localparam int          NVEC  = 8;

  // {addr, cmd, count, data[63:0], nbytes}
  localparam logic [91:0] VEC [NVEC] = '{
    {8'hD2, 8'h00, 8'h08, 64'h01_23_45_67_89_AB_CD_EF, 4'd11},
    {8'hD2, 8'hA5, 8'h3C, 64'hFF_FF_FF_FF_FF_FF_FF_FF, 4'd11},
    {8'hD3, 8'h00, 8'h08, 64'h11_11_11_11_11_11_11_11, 4'd11},
    {8'h52, 8'h00, 8'h08, 64'h22_22_22_22_22_22_22_22, 4'd11},
    {8'hD2, 8'h00, 8'h08, 64'h5A_5A_5A_5A_5A_5A_5A_5A, 4'd7},
    {8'hD2, 8'h77, 8'h08, 64'h33_33_33_33_33_33_33_33, 4'd10},
    {8'hD2, 8'h00, 8'h08, 64'h44_44_44_44_44_44_44_44, 4'd12},
    {8'hD2, 8'h9C, 8'h00, 64'h00_12_34_56_78_9A_BC_DE, 4'd11}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_pull_o;
  logic [63:0] cfg_o, oe_o;
  logic [63:0] model;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull_o;

  cfg_smb_sink dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .cfg_o(cfg_o), .oe_o(oe_o)
  );

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitq(1);
    m_scl = 1'b1; waitq(1);
    m_sda = 1'b0; waitq(1);
    m_scl = 1'b0; waitq(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq(1);
    m_scl = 1'b1; waitq(1);
    m_sda = 1'b1; waitq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; waitq(1);
      m_scl = 1'b1; waitq(2);
      m_scl = 1'b0; waitq(1);
    end
    m_sda = 1'b1; waitq(1);
    m_scl = 1'b1; waitq(1);
    acked = (sda_line == 1'b0);
    waitq(1);
    m_scl = 1'b0; waitq(1);
  endtask

  function automatic logic [7:0] byte_of(input logic [91:0] v, input int k);
    if (k == 0) return v[91:84];
    if (k == 1) return v[83:76];
    if (k == 2) return v[75:68];
    if (k <= 10) return v[4 + 8*(k-3) +: 8];
    return v[11:4];
  endfunction

  // Sends nbytes of the vector after a start; checks acknowledges per byte.
  task automatic send_bytes(input logic [91:0] v, input int nb);
    logic a;
    for (int k = 0; k < nb; k++) begin
      send_byte(byte_of(v, k), a);
      chk((v[91:84] == 8'hD2) ? ((k < 11) ? "R5 ack" : "R9 no ack")
                               : "R3 no ack",
          {63'd0, a}, {63'd0, (v[91:84] == 8'hD2) && (k < 11)});
    end
  endtask

  initial begin : main
    logic [91:0] v;
    logic        commit;
    string       tag;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    model = DEFV;
    chk("R1 cfg", cfg_o, DEFV);
    chk("R1 oe", oe_o, DEFV & ~MASK);
    chk("R1 pull", {63'd0, sda_pull_o}, 64'd0);

    for (int n = 0; n < NVEC; n++) begin
      v = VEC[n];
      commit = (v[91:84] == 8'hD2) && (v[3:0] == 4'd11);
      if (commit) tag = (v[83:76] != 8'h00) ? "R4 cfg" : "R2 cfg";
      else if (v[91:84] != 8'hD2) tag = "R3 cfg";
      else if (v[3:0] == 4'd10) tag = "R4 short cfg";
      else if (v[3:0] < 4'd11) tag = "R6 cfg";
      else tag = "R9 cfg";
      bus_start();
      send_bytes(v, int'(v[3:0]));
      bus_stop();
      waitq(2);
      if (commit) model = v[67:4];
      chk(tag, cfg_o, model);
      chk("R8 oe", oe_o, model & ~MASK);
      chk("R5 idle pull", {63'd0, sda_pull_o}, 64'd0);
    end

    // R7: repeated start after a partial frame, then a complete frame.
    bus_start();
    send_bytes({8'hD2, 8'h00, 8'h08, 64'hAA_AA_AA_AA_AA_AA_AA_AA, 4'd6}, 6);
    bus_start();
    send_bytes({8'hD2, 8'h01, 8'h02, 64'h0F_1E_2D_3C_4B_5A_69_78, 4'd11}, 11);
    bus_stop();
    waitq(2);
    model = 64'h0F_1E_2D_3C_4B_5A_69_78;
    chk("R7 restart load", cfg_o, model);

    // R7: repeated start then only a partial frame; nothing loads.
    bus_start();
    send_bytes({8'hD2, 8'h00, 8'h08, 64'hCC_CC_CC_CC_CC_CC_CC_CC, 4'd9}, 9);
    bus_start();
    send_bytes({8'hD2, 8'h00, 8'h08, 64'hDD_DD_DD_DD_DD_DD_DD_DD, 4'd4}, 4);
    bus_stop();
    waitq(2);
    chk("R7 restart partial", cfg_o, model);

    // R1: reset after writes restores defaults.
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 re-reset cfg", cfg_o, DEFV);
    chk("R1 re-reset oe", oe_o, DEFV & ~MASK);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule